// File: doc/BRIEF.md
# Cascadable Dual 8-bit Timer/Counter

This block holds two 8-bit count channels. Each channel can run on its own with its own count source, or a mode bit joins the two into one 16-bit counter. A count source is either one of several clock-enable taps from an external prescaler, or rising edges on an external event pin. When a source is an event pin, the channel works as an event counter. A channel advances once per tick of its source. When it reaches its programmed reload value, the next tick returns it to zero instead. That same tick sets the channel's interrupt flag, toggles its square-wave output and fires a one-cycle conversion-start pulse for an A/D converter.

Software sets the block up through a small write port with four byte registers. Address 0 is the control of channel 0, address 1 is the control of channel 1, address 2 is the reload of channel 0 and address 3 is the reload of channel 1. A control byte has these fields: bits [2:0] select the source, bit 3 is the run bit, bit 4 is the joined-mode bit (at address 0 only), and bit 5 is a write-one flag clear that is not stored. Both live counts are visible on output ports.

Top module: `tmr_cascade_pair`

## Requirements
- R1: After reset both counts are 0, both channels are stopped in separate mode, and the square-wave, interrupt and conversion-start outputs are all 0.
- R2: In separate mode each channel counts only ticks of its own source. Source code k (0 to 3) selects prescaler tap `pre_tick_i[k]`. Code 4 selects rising edges of the event pin. Codes 5 to 7 select no source. A running channel advances by one on each tick of its source, and one tap may feed one channel and not the other.
- R3: A tick that arrives while the count equals the reload value sets the count to 0 rather than advancing it. The same tick toggles that channel's square-wave output, so after n ticks from zero with reload r the count is n mod (r+1).
- R4: Every reload match produces exactly one conversion-start pulse, one cycle high. The pulse appears at the same clock edge at which the count returns to 0, and the output stays low in every other cycle.
- R5: With the joined-mode bit set at address 0, channel 0 is the low byte and channel 1 is the high byte. The pair takes its source and run bit from address 0. The high byte advances only when the low byte rolls over from 255. The match compares all 16 bits against {reload 1, reload 0}. A match acts on the interrupt flag and square-wave output of channel 0 only. The source and run settings of channel 1 have no effect on either count, and its square-wave and flag outputs do not change.
- R6: The event pin passes through two synchronising flops followed by rising-edge detection. A rise first counts at the third clock edge after it, and a pin held high counts only once.
- R7: While a channel's run bit is 0, its count holds. A write that changes the run bit from 0 to 1 clears the count to 0; in joined mode the start clears both bytes. Writing run=1 to a channel that is already running leaves its count alone.
- R8: A channel's interrupt output is a sticky flag, set by a match and cleared by writing a 1 to bit 5 of that channel's control byte. When a match and a clear land in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0/1 controls, 2/3 reloads |
| wr_data_i | input | 8 | Register write data |
| pre_tick_i | input | 4 | One-cycle clock-enable taps from the prescaler |
| evt_i | input | 1 | Asynchronous external event pin |
| cnt_lo_o | output | 8 | Channel 0 count (low byte in joined mode) |
| cnt_hi_o | output | 8 | Channel 1 count (high byte in joined mode) |
| sq_o | output | 2 | Square-wave outputs, one per channel |
| irq_o | output | 2 | Sticky interrupt flags, one per channel |
| adc_start_o | output | 1 | One-cycle conversion-start pulse on any match |

## Verification
The hardest state to reach is the joined-mode rollover. Getting there means 255 low-byte ticks, then a carry into the high byte, then a full 16-bit match, while channel 1's own source keeps ticking and must be ignored. The stimulus holds a prescaler tap high for long runs to cover the distance quickly. It pulses channel 1's tap at the 0x00FF boundary and steps tick by tick to the match. A second corner puts a match and a flag-clear write in the same cycle. Randomised runs with random reload values and tick counts then compare counts, square-wave parity, flags and pulse counts against closed-form expectations.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  parameter int unsigned CW   = 8;
  parameter int unsigned NTAP = 4;
  localparam int unsigned SELW = $clog2(NTAP + 1);
  localparam int unsigned NCH  = 2;

  typedef logic [SELW-1:0] csel_t;
  typedef logic [CW-1:0]   cnt_t;

  localparam csel_t SEL_EVT = csel_t'(NTAP);

  localparam logic [1:0] ADDR_CTL0 = 2'd0;
  localparam logic [1:0] ADDR_CTL1 = 2'd1;
  localparam logic [1:0] ADDR_RL0  = 2'd2;
  localparam logic [1:0] ADDR_RL1  = 2'd3;

  localparam int unsigned BIT_RUN  = 3;
  localparam int unsigned BIT_CASC = 4;
  localparam int unsigned BIT_CLR  = 5;
endpackage

// File: rtl/tmr_evt_sync.sv
module tmr_evt_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o
);
  logic s1_q, s2_q, d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      d_q  <= 1'b0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      d_q  <= s2_q;
    end
  end

  assign rise_o = s2_q & ~d_q;

  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o); // R6
endmodule

// File: rtl/tmr_src_mux.sv
module tmr_src_mux
  import tmr_pkg::*;
(
  input  csel_t           sel_i,
  input  logic [NTAP-1:0] taps_i,
  input  logic            evt_rise_i,
  output logic            tick_o
);
  logic [NTAP-1:0] tap_hit;

  for (genvar k = 0; k < NTAP; k++) begin : g_tap
    assign tap_hit[k] = taps_i[k] & (sel_i == csel_t'(k));
  end

  always_comb begin
    tick_o = |tap_hit;
    if (sel_i == SEL_EVT) tick_o = evt_rise_i;
  end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic adv_i,
  input  logic zero_i,
  output cnt_t cnt_o
);
  cnt_t cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i || zero_i) cnt_d = '0;
    else if (adv_i)      cnt_d = cnt_q + cnt_t'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tmr_cascade_pair.sv
module tmr_cascade_pair
  import tmr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en_i,
  input  logic [1:0]      wr_addr_i,
  input  logic [7:0]      wr_data_i,
  input  logic [NTAP-1:0] pre_tick_i,
  input  logic            evt_i,
  output logic [CW-1:0]   cnt_lo_o,
  output logic [CW-1:0]   cnt_hi_o,
  output logic [1:0]      sq_o,
  output logic [1:0]      irq_o,
  output logic            adc_start_o
);
  localparam cnt_t CNT_MAX = '1;

  csel_t    csel_q [NCH];
  cnt_t     rl_q   [NCH];
  cnt_t     cnt    [NCH];
  logic [NCH-1:0] run_q, flag_q, sq_q;
  logic     casc_q, adc_q;

  logic [NCH-1:0] wr_ctl, start, clr_flag, tick, go, hit;
  logic [NCH-1:0] ch_clr, ch_adv, ch_zero;
  logic [NCH-1:0] flag_d, sq_d;
  logic     evt_rise, full_match;

  tmr_evt_sync u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (evt_i),
    .rise_o (evt_rise)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign wr_ctl[i]   = wr_en_i && (wr_addr_i == (i == 0 ? ADDR_CTL0 : ADDR_CTL1));
    assign start[i]    = wr_ctl[i] && wr_data_i[BIT_RUN] && !run_q[i];
    assign clr_flag[i] = wr_ctl[i] && wr_data_i[BIT_CLR];
    assign go[i]       = tick[i] && run_q[i];

    tmr_src_mux u_mux (
      .sel_i      (csel_q[i]),
      .taps_i     (pre_tick_i),
      .evt_rise_i (evt_rise),
      .tick_o     (tick[i])
    );

    tmr_chan u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (ch_clr[i]),
      .adv_i  (ch_adv[i]),
      .zero_i (ch_zero[i]),
      .cnt_o  (cnt[i])
    );
  end

  assign full_match = ({cnt[1], cnt[0]} == {rl_q[1], rl_q[0]});

  always_comb begin
    hit[0] = go[0] && (casc_q ? full_match : (cnt[0] == rl_q[0]));
    hit[1] = !casc_q && go[1] && (cnt[1] == rl_q[1]);

    ch_clr[0]  = start[0];
    ch_adv[0]  = go[0] && !hit[0];
    ch_zero[0] = hit[0];

    if (casc_q) begin
      ch_clr[1]  = start[0];
      ch_adv[1]  = go[0] && !hit[0] && (cnt[0] == CNT_MAX);
      ch_zero[1] = hit[0];
    end else begin
      ch_clr[1]  = start[1];
      ch_adv[1]  = go[1] && !hit[1];
      ch_zero[1] = hit[1];
    end

    flag_d = hit | (flag_q & ~clr_flag);
    sq_d   = sq_q ^ hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csel_q[0] <= '0;
      csel_q[1] <= '0;
      rl_q[0]   <= '0;
      rl_q[1]   <= '0;
      run_q     <= '0;
      casc_q    <= 1'b0;
      flag_q    <= '0;
      sq_q      <= '0;
      adc_q     <= 1'b0;
    end else begin
      flag_q <= flag_d;
      sq_q   <= sq_d;
      adc_q  <= |hit;
      if (wr_en_i) begin
        case (wr_addr_i)
          ADDR_CTL0: begin
            csel_q[0] <= wr_data_i[SELW-1:0];
            run_q[0]  <= wr_data_i[BIT_RUN];
            casc_q    <= wr_data_i[BIT_CASC];
          end
          ADDR_CTL1: begin
            csel_q[1] <= wr_data_i[SELW-1:0];
            run_q[1]  <= wr_data_i[BIT_RUN];
          end
          ADDR_RL0: rl_q[0] <= wr_data_i[CW-1:0];
          default:  rl_q[1] <= wr_data_i[CW-1:0];
        endcase
      end
    end
  end

  assign cnt_lo_o    = cnt[0];
  assign cnt_hi_o    = cnt[1];
  assign sq_o        = sq_q;
  assign irq_o       = flag_q;
  assign adc_start_o = adc_q;

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    hit[0] |=> (cnt_lo_o == '0)); // R3
  AST_SQ_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    hit[0] |=> (sq_o[0] != $past(sq_o[0]))); // R3
  AST_ADC_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |=> adc_start_o); // R4
  AST_ADC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (hit == '0) |=> !adc_start_o); // R4
  AST_HIGH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (casc_q && !hit[0] && (cnt_lo_o != CNT_MAX) && !start[0]) |=> $stable(cnt_hi_o)); // R5
  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q[0] && !(wr_en_i && wr_addr_i == ADDR_CTL0)) |=> $stable(cnt_lo_o)); // R7
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    hit[0] |=> irq_o[0]); // R8
endmodule

// File: tb/tmr_cascade_pair_tb_top.sv
module tmr_cascade_pair_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] pre_tick = '0;
  logic       evt = 1'b0;
  logic [7:0] cnt_lo, cnt_hi;
  logic [1:0] sq, irq;
  logic       adc;

  int checks = 0;
  int fails  = 0;
  int adc_seen = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tmr_cascade_pair dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en_i     (wr_en),
    .wr_addr_i   (wr_addr),
    .wr_data_i   (wr_data),
    .pre_tick_i  (pre_tick),
    .evt_i       (evt),
    .cnt_lo_o    (cnt_lo),
    .cnt_hi_o    (cnt_hi),
    .sq_o        (sq),
    .irq_o       (irq),
    .adc_start_o (adc)
  );

  always @(negedge clk) if (rst_n && adc) adc_seen++;

  function automatic int exp_cnt(int n, int rl);
    return n % (rl + 1);
  endfunction

  function automatic int exp_wraps(int n, int rl);
    return n / (rl + 1);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick_n(logic [3:0] m, int n);
    if (n > 0) begin
      @(negedge clk);
      pre_tick = m;
      repeat (n) @(negedge clk);
      pre_tick = '0;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int a0, s0, r, ch, rl, n;
    r = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cnt_lo", cnt_lo, 0);
    chk("R1 cnt_hi", cnt_hi, 0);
    chk("R1 sq", sq, 0);
    chk("R1 irq", irq, 0);
    chk("R1 adc", adc, 0);

    // R2/R3/R4 channel 0 on tap 0, reload 5, 13 ticks
    wr(2, 8'd5);
    wr(0, 8'h08);
    a0 = adc_seen;
    tick_n(4'b0001, 13);
    chk("R3 cnt0 mod", cnt_lo, exp_cnt(13, 5));
    chk("R3 sq0 parity", sq[0], exp_wraps(13, 5) & 1);
    chk("R8 irq0 set", irq[0], 1);
    chk("R4 adc pulses", adc_seen - a0, exp_wraps(13, 5));

    // R7 stop holds count
    wr(0, 8'h00);
    tick_n(4'b0001, 5);
    chk("R7 hold stopped", cnt_lo, 1);

    // R2 channel 1 on tap 2 ignores tap 0
    wr(3, 8'd3);
    wr(1, 8'h0A);
    tick_n(4'b0001, 4);
    chk("R2 ch1 ignores tap0", cnt_hi, 0);
    tick_n(4'b0100, 7);
    chk("R2 ch1 tap2 count", cnt_hi, exp_cnt(7, 3));
    chk("R3 sq1 parity", sq[1], exp_wraps(7, 3) & 1);
    chk("R2 ch0 untouched", cnt_lo, 1);

    // R7 restart clears
    wr(0, 8'h08);
    chk("R7 start clears", cnt_lo, 0);
    // R8 clear flag while running, count kept
    tick_n(4'b0001, 2);
    wr(0, 8'h28);
    chk("R8 flag cleared", irq[0], 0);
    chk("R7 rerun keeps count", cnt_lo, 2);
    // R8 match and clear in the same cycle
    tick_n(4'b0001, 3);
    chk("R3 at reload", cnt_lo, 5);
    @(negedge clk);
    pre_tick = 4'b0001; wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'h28;
    @(negedge clk);
    pre_tick = '0; wr_en = 1'b0;
    @(negedge clk);
    chk("R8 set wins", irq[0], 1);
    chk("R3 wrap to zero", cnt_lo, 0);

    // R6 event input on channel 0
    wr(0, 8'h00);
    wr(0, 8'h0C);
    chk("R7 start clears evt", cnt_lo, 0);
    evt = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R6 not yet counted", cnt_lo, 0);
    @(negedge clk);
    chk("R6 counted third edge", cnt_lo, 1);
    repeat (5) @(negedge clk);
    chk("R6 held high once", cnt_lo, 1);
    evt = 1'b0;
    repeat (3) @(negedge clk);
    evt = 1'b1;
    repeat (4) @(negedge clk);
    chk("R6 second rise", cnt_lo, 2);
    evt = 1'b0;

    // R5 joined mode, target 0x0102
    wr(0, 8'h10);
    wr(2, 8'h02);
    wr(3, 8'h01);
    wr(1, 8'h2A);
    wr(0, 8'h38);
    s0 = sq[1];
    a0 = adc_seen;
    chk("R5 start clears lo", cnt_lo, 0);
    chk("R5 start clears hi", cnt_hi, 0);
    tick_n(4'b0001, 255);
    chk("R5 lo at 255", cnt_lo, 255);
    chk("R5 hi held", cnt_hi, 0);
    tick_n(4'b0100, 3);
    chk("R5 ch1 source ignored", cnt_hi, 0);
    tick_n(4'b0001, 1);
    chk("R5 carry lo", cnt_lo, 0);
    chk("R5 carry hi", cnt_hi, 1);
    tick_n(4'b0001, 2);
    chk("R5 no early match", irq[0], 0);
    tick_n(4'b0001, 1);
    chk("R5 wrap lo", cnt_lo, 0);
    chk("R5 wrap hi", cnt_hi, 0);
    chk("R5 irq0", irq[0], 1);
    chk("R5 irq1 untouched", irq[1], 0);
    chk("R5 sq1 untouched", sq[1], s0);
    chk("R4 joined pulse", adc_seen - a0, 1);

    // Random separate-mode runs
    wr(0, 8'h00);
    wr(1, 8'h00);
    for (int it = 0; it < 20; it++) begin
      ch = $urandom % 2;
      rl = $urandom % 16;
      n  = $urandom % 50;
      wr(2'(2 + ch), 8'(rl));
      wr(2'(ch), 8'h00);
      s0 = sq[ch];
      a0 = adc_seen;
      wr(2'(ch), 8'h28);
      tick_n(4'b0001, n);
      chk("R3 rnd cnt", (ch == 0) ? cnt_lo : cnt_hi, exp_cnt(n, rl));
      chk("R3 rnd sq", sq[ch], s0 ^ (exp_wraps(n, rl) & 1));
      chk("R8 rnd irq", irq[ch], (n > rl) ? 1 : 0);
      chk("R4 rnd adc", adc_seen - a0, exp_wraps(n, rl));
      wr(2'(ch), 8'h00);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule